// File: doc/BRIEF.md
# Audio Converter Clock-Rate and Frame Timing Generator

This block derives the bit-clock and left/right frame-clock timing of a stereo converter's capture path from a single master clock. It does not multiply any clock. The internal clock-rate scaler is modelled as a count of internal clock ticks per master-clock cycle: two ticks (double), one tick (bypass), or two ticks every three cycles (two-thirds). A free-running tick counter turns those ticks into a frame of 512 internal ticks, or 256 when the fast-rate input is set. The frame carries 64 bit-clock periods, with the left half first.

The scaler setting can be written only during a fixed window of master-clock cycles after reset. A write after that window leaves both the setting and the output timing unchanged. A mode input picks the direction of the framing pins. In master mode the block drives the bit clock and frame clock. In slave mode the block drives both low, synchronises the external clocks, and reports each frame start with a one-cycle pulse and a count of received bit-clock rising edges. A small decoder also turns the two-bit playback interpolation code into an interpolation ratio.

Two state machines do the control work:
- **Window FSM.** States `WIN_OPEN` and `WIN_LOCKED`. The single transition, *close*, fires on the last cycle of the window.
- **Slave-sync FSM.** States `SY_HUNT` and `SY_LOCKED`. The transition *lock* fires on a synchronised rising frame-clock edge in slave mode. The transition *drop* fires whenever master mode is selected.

Top module: `acodec_clkgen`

## Requirements
- R1: While reset is held and just after it is released, the block shows: `scale_window`=1, `scale_cfg`=00, `bclk_o`=0, `lrclk_o`=0, `frame_sof`=0.
- R2: The scaler code sets the internal ticks per master cycle on `ick_ticks`:
  - 00 gives 2 per cycle (double).
  - 01 gives 1 per cycle (bypass).
  - 10 gives the pattern 1,1,0, which is 2 per 3 cycles.
  - 11 is reserved, is stored as written, and behaves like 00.
- R3: A write (`scale_wr`=1) is accepted at each of the first 3072 rising edges after reset release. `scale_window` is 1 for exactly those cycles. A write at any later edge is ignored: `scale_cfg` and the frame period stay as they were.
- R4: In master mode a frame is 512 internal ticks when `fs_double`=0 and 256 internal ticks when `fs_double`=1. The resulting frame periods in master cycles are:
  - 256 or 128 for scaler code 00 or 11.
  - 512 or 256 for code 01.
  - 768 or 384 for code 10.
- R5: In master mode `bclk_o` has exactly 64 rising edges per frame.
- R6: In master mode `lrclk_o` is low (left channel) for the first half of each frame and high (right channel) for the second half. It starts low after reset and after entering master mode.
- R7: `clk_drive_en` equals `ms_master`. In slave mode `bclk_o` and `lrclk_o` are held at 0 and the frame generator restarts at frame start. `frame_sof` is never 1 in master mode.
- R8: In slave mode `frame_sof` stays 0 until a rising edge of `lrclk_i` has been seen. After that, each falling edge of `lrclk_i` gives exactly one `frame_sof` pulse of one cycle, visible in the second cycle after the new level is applied (two-stage synchroniser).
- R9: In slave mode `slave_bit_cnt` counts synchronised rising edges of `bclk_i` and is cleared to 0 by each falling edge of `lrclk_i`.
- R10: `interp_rate` decodes `interp_code` as follows: 00 gives 8, 01 gives 4, 10 gives 2, and the reserved 11 gives 8.
- R11: Selecting master mode returns the slave synchroniser to hunting. After returning to slave mode, no `frame_sof` occurs until a new rising edge of `lrclk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scale_wr | input | 1 | Scaler write strobe |
| scale_code | input | 2 | Scaler code to write |
| fs_double | input | 1 | 1 selects a 256-tick frame, 0 selects a 512-tick frame |
| interp_code | input | 2 | Playback interpolation select code |
| ms_master | input | 1 | 1 = master (drive framing pins), 0 = slave |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrclk_o | output | 1 | Generated frame clock, low = left (master mode) |
| clk_drive_en | output | 1 | Output enable for the framing pins |
| scale_cfg | output | 2 | Scaler code in force |
| scale_window | output | 1 | 1 while scaler writes are accepted |
| ick_ticks | output | 2 | Internal clock ticks this master cycle |
| interp_rate | output | 4 | Decoded interpolation ratio |
| frame_sof | output | 1 | One-cycle start-of-frame pulse (slave mode) |
| slave_bit_cnt | output | 6 | Bit-clock rising edges since the last frame start |

## Verification
The bench targets these corner cases and the failure each one would show:
- **Window boundary.** A write arrives on the last accepted edge and another on the first rejected edge. An off-by-one window either loses the first write or lets the second change the scaler, and the frame period then shows the wrong setting.
- **Uneven two-thirds ratio and reserved scaler code.** A wrong tick pattern or a wrong fallback gives a frame period other than 768/384 or 256.
- **Slave synchroniser.**
  - A falling frame edge before any rising edge must produce no pulse.
  - A pulse must appear in the second cycle after the edge and last one cycle.
  - A visit to master mode must force a fresh hunt, so a design that stays locked would give an early pulse.
  - The bit count must be cleared at frame start.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef enum logic [1:0] {
        SC_X2   = 2'b00,
        SC_X1   = 2'b01,
        SC_X2_3 = 2'b10,
        SC_RSVD = 2'b11
    } scale_e;

    typedef enum logic {
        WIN_OPEN   = 1'b0,
        WIN_LOCKED = 1'b1
    } win_state_e;

    typedef enum logic {
        SY_HUNT   = 1'b0,
        SY_LOCKED = 1'b1
    } sync_state_e;

endpackage

// File: rtl/acg_scaler.sv
module acg_scaler
    import acg_pkg::*;
#(
    parameter int WINDOW_CYCLES = 3072
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] code,
    output logic [1:0] cfg,
    output logic       win_open,
    output logic [1:0] ticks
);

    localparam int WCW = $clog2(WINDOW_CYCLES);
    localparam logic [WCW-1:0] LAST = WCW'(WINDOW_CYCLES - 1);

    win_state_e     st, st_nx;
    logic [WCW-1:0] wcnt;
    logic [1:0]     ph;
    scale_e         cfg_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= WIN_OPEN;
        else        st <= st_nx;
    end

    // next state: "close" on the last window cycle
    always_comb begin
        st_nx = st;
        unique case (st)
            WIN_OPEN:   if (wcnt == LAST) st_nx = WIN_LOCKED;
            WIN_LOCKED: st_nx = WIN_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt  <= '0;
            cfg_q <= SC_X2;
            ph    <= 2'd0;
        end else begin
            if (st == WIN_OPEN) wcnt <= wcnt + 1'b1;
            if (st == WIN_OPEN && wr) cfg_q <= scale_e'(code);
            ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
        end
    end

    // outputs
    always_comb begin
        win_open = (st == WIN_OPEN);
        cfg      = cfg_q;
        unique case (cfg_q)
            SC_X2, SC_RSVD: ticks = 2'd2;
            SC_X1:          ticks = 2'd1;
            SC_X2_3:        ticks = (ph == 2'd2) ? 2'd0 : 2'd1;
        endcase
    end

    // R3
    win_stays_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> !win_open);

    // R3
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(cfg));

endmodule

// File: rtl/acg_master_gen.sv
module acg_master_gen #(
    parameter int FRAME_LONG     = 512,
    parameter int FRAME_SHORT    = 256,
    parameter int BCLK_PER_FRAME = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master,
    input  logic       fs_double,
    input  logic [1:0] ticks,
    output logic       bclk_o,
    output logic       lrclk_o
);

    localparam int CW        = $clog2(FRAME_LONG);
    localparam int L_BCK_BIT = $clog2(FRAME_LONG / (2 * BCLK_PER_FRAME));
    localparam int S_BCK_BIT = $clog2(FRAME_SHORT / (2 * BCLK_PER_FRAME));
    localparam int L_LR_BIT  = CW - 1;
    localparam int S_LR_BIT  = $clog2(FRAME_SHORT) - 1;
    localparam logic [CW-1:0] S_MASK = CW'(FRAME_SHORT - 1);

    logic [CW-1:0] cnt, cnt_sum;

    assign cnt_sum = cnt + CW'(ticks);

    always_ff @(posedge clk) begin
        if (!rst_n || !master) cnt <= '0;
        else if (fs_double)    cnt <= cnt_sum & S_MASK;
        else                   cnt <= cnt_sum;
    end

    always_comb begin
        if (fs_double) begin
            bclk_o  = master & cnt[S_BCK_BIT];
            lrclk_o = master & cnt[S_LR_BIT];
        end else begin
            bclk_o  = master & cnt[L_BCK_BIT];
            lrclk_o = master & cnt[L_LR_BIT];
        end
    end

    // R6
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master) |=> !lrclk_o);

    // R4
    short_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && fs_double) |=> !cnt[CW-1]);

endmodule

// File: rtl/acg_slave_sync.sv
module acg_slave_sync
    import acg_pkg::*;
#(
    parameter int BITS_PER_FRAME = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              master,
    input  logic                              bclk_i,
    input  logic                              lrclk_i,
    output logic                              sof,
    output logic [$clog2(BITS_PER_FRAME)-1:0] bit_cnt
);

    localparam int BCW = $clog2(BITS_PER_FRAME);

    sync_state_e st, st_nx;
    logic [2:0]  lr_s;
    logic [2:0]  bc_s;
    logic        lr_rise, lr_fall, bc_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_s <= 3'b111;
            bc_s <= 3'b000;
        end else begin
            lr_s <= {lr_s[1:0], lrclk_i};
            bc_s <= {bc_s[1:0], bclk_i};
        end
    end

    assign lr_rise = ~lr_s[2] &  lr_s[1];
    assign lr_fall =  lr_s[2] & ~lr_s[1];
    assign bc_rise = ~bc_s[2] &  bc_s[1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SY_HUNT;
        else        st <= st_nx;
    end

    // next state: "lock" on rising frame edge, "drop" on master mode
    always_comb begin
        st_nx = st;
        unique case (st)
            SY_HUNT:   if (!master && lr_rise) st_nx = SY_LOCKED;
            SY_LOCKED: if (master)             st_nx = SY_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        sof = (st == SY_LOCKED) && !master && lr_fall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       bit_cnt <= '0;
        else if (lr_fall) bit_cnt <= '0;
        else if (bc_rise) bit_cnt <= bit_cnt + BCW'(1);
    end

    // R8
    sof_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    // R11
    hunt_after_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master) |-> !sof);

endmodule

// File: rtl/acg_interp_dec.sv
module acg_interp_dec (
    input  logic [1:0] code,
    output logic [3:0] rate
);

    always_comb begin
        unique case (code)
            2'b01:          rate = 4'd4;
            2'b10:          rate = 4'd2;
            2'b00, 2'b11:   rate = 4'd8;
        endcase
    end

endmodule

// File: rtl/acodec_clkgen.sv
module acodec_clkgen #(
    parameter int WINDOW_CYCLES  = 3072,
    parameter int FRAME_LONG     = 512,
    parameter int FRAME_SHORT    = 256,
    parameter int BCLK_PER_FRAME = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              scale_wr,
    input  logic [1:0]                        scale_code,
    input  logic                              fs_double,
    input  logic [1:0]                        interp_code,
    input  logic                              ms_master,
    input  logic                              bclk_i,
    input  logic                              lrclk_i,
    output logic                              bclk_o,
    output logic                              lrclk_o,
    output logic                              clk_drive_en,
    output logic [1:0]                        scale_cfg,
    output logic                              scale_window,
    output logic [1:0]                        ick_ticks,
    output logic [3:0]                        interp_rate,
    output logic                              frame_sof,
    output logic [$clog2(BCLK_PER_FRAME)-1:0] slave_bit_cnt
);

    assign clk_drive_en = ms_master;

    acg_scaler #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_scaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (scale_wr),
        .code     (scale_code),
        .cfg      (scale_cfg),
        .win_open (scale_window),
        .ticks    (ick_ticks)
    );

    acg_master_gen #(
        .FRAME_LONG    (FRAME_LONG),
        .FRAME_SHORT   (FRAME_SHORT),
        .BCLK_PER_FRAME(BCLK_PER_FRAME)
    ) u_mgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .master    (ms_master),
        .fs_double (fs_double),
        .ticks     (ick_ticks),
        .bclk_o    (bclk_o),
        .lrclk_o   (lrclk_o)
    );

    acg_slave_sync #(.BITS_PER_FRAME(BCLK_PER_FRAME)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .master  (ms_master),
        .bclk_i  (bclk_i),
        .lrclk_i (lrclk_i),
        .sof     (frame_sof),
        .bit_cnt (slave_bit_cnt)
    );

    acg_interp_dec u_idec (
        .code (interp_code),
        .rate (interp_rate)
    );

    // R7
    no_sof_in_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_master |-> !frame_sof);

endmodule

// File: tb/acodec_clkgen_tb.sv
`timescale 1ns/1ps
module acodec_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scale_wr = 1'b0;
    logic [1:0] scale_code = 2'b00;
    logic       fs_double = 1'b0;
    logic [1:0] interp_code = 2'b00;
    logic       ms_master = 1'b1;
    logic       bclk_i = 1'b0;
    logic       lrclk_i = 1'b1;
    logic       bclk_o, lrclk_o, clk_drive_en, scale_window, frame_sof;
    logic [1:0] scale_cfg, ick_ticks;
    logic [3:0] interp_rate;
    logic [5:0] slave_bit_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    acodec_clkgen u_dut (
        .clk(clk), .rst_n(rst_n), .scale_wr(scale_wr), .scale_code(scale_code),
        .fs_double(fs_double), .interp_code(interp_code), .ms_master(ms_master),
        .bclk_i(bclk_i), .lrclk_i(lrclk_i), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
        .clk_drive_en(clk_drive_en), .scale_cfg(scale_cfg), .scale_window(scale_window),
        .ick_ticks(ick_ticks), .interp_rate(interp_rate), .frame_sof(frame_sof),
        .slave_bit_cnt(slave_bit_cnt)
    );

    // {scaler code, fs_double, ticks per 3 cycles, frame period in cycles}
    localparam logic [15:0] VEC [7] = '{
        {2'b00, 1'b0, 3'd6, 10'd256},
        {2'b00, 1'b1, 3'd6, 10'd128},
        {2'b01, 1'b0, 3'd3, 10'd512},
        {2'b01, 1'b1, 3'd3, 10'd256},
        {2'b10, 1'b0, 3'd2, 10'd768},
        {2'b10, 1'b1, 3'd2, 10'd384},
        {2'b11, 1'b0, 3'd6, 10'd256}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic mst);
        @(negedge clk);
        rst_n = 1'b0; scale_wr = 1'b0; ms_master = mst;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic measure_frame(output int per, output int bck, output int hi);
        logic pl, pb;
        int g;
        per = 0; bck = 0; hi = 0; g = 0;
        pl = lrclk_o;
        step(1);
        while (!(!pl && lrclk_o) && g < 3000) begin
            pl = lrclk_o; step(1); g++;
        end
        pl = lrclk_o; pb = bclk_o;
        g = 0;
        do begin
            step(1); per++; g++;
            if (!pb && bclk_o) bck++;
            if (lrclk_o) hi++;
            pb = bclk_o;
            if (!pl && lrclk_o) break;
            pl = lrclk_o;
        end while (g < 3000);
    endtask

    task automatic slv_drive(input logic lr, input logic bc, output int nsof, output int idx);
        lrclk_i = lr; bclk_i = bc;
        nsof = 0; idx = 0;
        for (int k = 1; k <= 6; k++) begin
            step(1);
            if (frame_sof) begin nsof++; if (idx == 0) idx = k; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int per, bck, hi, sum, k, ns, ix;

        // R1 reset state
        step(2);
        chk("R1 window in reset", scale_window, 1);
        chk("R1 cfg in reset", scale_cfg, 0);
        do_reset(1'b1);
        chk("R1 window after release", scale_window, 1);
        chk("R1 cfg after release", scale_cfg, 0);
        chk("R1 bclk low", bclk_o, 0);
        chk("R6 lrclk starts low", lrclk_o, 0);
        chk("R1 sof low", frame_sof, 0);
        chk("R7 drive enable master", clk_drive_en, 1);

        // table of scaler/rate settings
        for (int i = 0; i < 7; i++) begin
            do_reset(1'b1);
            scale_code = VEC[i][15:14]; fs_double = VEC[i][13]; scale_wr = 1'b1;
            step(1);
            scale_wr = 1'b0;
            chk("R2 cfg stored", scale_cfg, VEC[i][15:14]);
            sum = 0;
            for (int j = 0; j < 3; j++) begin sum += ick_ticks; step(1); end
            chk("R2 ticks per 3 cycles", sum, VEC[i][12:10]);
            measure_frame(per, bck, hi);
            chk("R4 frame period", per, VEC[i][9:0]);
            chk("R5 bclk rises per frame", bck, 64);
            chk("R6 right half length", hi, VEC[i][9:0] / 2);
        end

        // R3 window boundary
        fs_double = 1'b0;
        do_reset(1'b1);
        k = 0;
        while (scale_window && k < 5000) begin
            k++;
            if (k == 3072) begin scale_code = 2'b01; scale_wr = 1'b1; end
            step(1);
            scale_wr = 1'b0;
        end
        chk("R3 window length", k, 3072);
        chk("R3 last-edge write taken", scale_cfg, 1);
        scale_code = 2'b10; scale_wr = 1'b1;
        step(1);
        scale_wr = 1'b0;
        step(2);
        chk("R3 late write ignored cfg", scale_cfg, 1);
        measure_frame(per, bck, hi);
        chk("R3 late write ignored period", per, 512);

        // R10 interpolation decode
        interp_code = 2'b00; step(1); chk("R10 code 00", interp_rate, 8);
        interp_code = 2'b01; step(1); chk("R10 code 01", interp_rate, 4);
        interp_code = 2'b10; step(1); chk("R10 code 10", interp_rate, 2);
        interp_code = 2'b11; step(1); chk("R10 code 11", interp_rate, 8);

        // slave mode
        lrclk_i = 1'b1; bclk_i = 1'b0;
        do_reset(1'b0);
        step(4);
        chk("R7 drive enable slave", clk_drive_en, 0);
        chk("R7 bclk held low", bclk_o, 0);
        chk("R7 lrclk held low", lrclk_o, 0);
        slv_drive(1'b0, 1'b0, ns, ix);
        chk("R8 no sof before rise", ns, 0);
        slv_drive(1'b1, 1'b0, ns, ix);
        chk("R8 no sof on rise", ns, 0);
        slv_drive(1'b0, 1'b0, ns, ix);
        chk("R8 one sof on fall", ns, 1);
        chk("R8 sof latency", ix, 2);
        for (int b = 0; b < 5; b++) begin
            slv_drive(1'b0, 1'b1, ns, ix);
            slv_drive(1'b0, 1'b0, ns, ix);
        end
        chk("R9 bit count", slave_bit_cnt, 5);
        slv_drive(1'b1, 1'b0, ns, ix);
        slv_drive(1'b0, 1'b0, ns, ix);
        chk("R8 sof next frame", ns, 1);
        chk("R9 bit count cleared", slave_bit_cnt, 0);

        // R11 master visit forces a fresh hunt
        slv_drive(1'b1, 1'b0, ns, ix);
        ms_master = 1'b1;
        step(4);
        chk("R7 no sof in master", frame_sof, 0);
        ms_master = 1'b0;
        step(4);
        slv_drive(1'b0, 1'b0, ns, ix);
        chk("R11 no sof after master visit", ns, 0);
        slv_drive(1'b1, 1'b0, ns, ix);
        slv_drive(1'b0, 1'b0, ns, ix);
        chk("R11 sof after new lock", ns, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule